// File: doc/BRIEF.md
# Lockable Upper DRAM Limit Decoder

This block keeps the top boundary of the DRAM that the operating system may use above the 4 GB line. It also decides, for every host address, whether that address falls inside DRAM. Software programs the boundary through a 64-bit configuration register. The register sits at a single fixed location and is written with per-byte enables. Only a 19-bit field holding address bits 38:20 of the boundary is stored, so the boundary has 1 MB granularity.

The register can be frozen in two ways:
- Software sets a sticky lock bit, which also freezes the lock bit itself.
- An external trusted-mode lock input is held high.

The decode output is high when the host address lies in the half-open window from 4 GB up to the programmed boundary. The boundary itself is excluded. If the boundary is 4 GB or lower, no address is inside DRAM.

Top module: `upper_dram_limit`

## Requirements
- R1: After reset, the register reads 0x0000_0000_0000_0000 and `dram_hit_o` is low for every host address.
- R2: A write (`cfg_sel_i` and `cfg_we_i` high at a rising clock edge) with the register unlocked and `tlock_i` low stores `cfg_wdata_i[38:20]` into the limit field and `cfg_wdata_i[0]` into the lock bit. The new value is visible on `cfg_rdata_o` from the cycle after the write strobe.
- R3: Bits 63:39 and 19:1 always read as zero, whatever has been written to them.
- R4: Byte enable bit n controls register bits 8n+7:8n. Limit bits 23:20 change only when enable bit 2 is set, bits 31:24 only with bit 3, bits 38:32 only with bit 4, and the lock bit only with bit 0. Bytes whose enable is clear keep their value.
- R5: Once the lock bit (bit 0) reads 1, later writes change neither the limit field nor the lock bit. Only reset clears the lock bit.
- R6: A write presented while `tlock_i` is high changes no bit of the register, the lock bit included.
- R7: `dram_hit_o` is 1 exactly when 0x1_0000_0000 <= `host_addr_i` < {limit, 20'h0}.
- R8: When the limit field is 0x01000 (4 GB) or lower, `dram_hit_o` stays low for every address.
- R9: `dram_hit_o` depends combinationally on `host_addr_i` and the current register value, with no clock cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_sel_i | input | 1 | Register selected for an access |
| cfg_we_i | input | 1 | Write strobe |
| cfg_be_i | input | 8 | Byte enables for the write |
| cfg_wdata_i | input | 64 | Write data |
| cfg_rdata_o | output | 64 | Current register image |
| tlock_i | input | 1 | Trusted-mode lock; blocks every write while high |
| host_addr_i | input | 39 | Host address to decode |
| dram_hit_o | output | 1 | Address falls in the upper DRAM window |

## Verification
A write lands on the rising edge that samples the strobe. The readback and the decode window therefore change one cycle after the write request, and the bench checks both at the falling edge that follows. The decode result and the register image carry no further delay. So the bench changes `host_addr_i` between edges, lets one time unit pass, and compares `dram_hit_o` in the same cycle. Expected values go into a scoreboard queue only after the stimulus has settled. The monitor takes each value before the driver moves the inputs again.

// File: rtl/udl_pkg.sv
package udl_pkg;
  localparam int REG_W    = 64;
  localparam int LIM_LSB  = 20;
  localparam int LIM_MSB  = 38;
  localparam int LIM_W    = LIM_MSB - LIM_LSB + 1;
  localparam int LOCK_POS = 0;
  localparam int BYTES    = REG_W / 8;
  localparam int GB4_BIT  = 32;
  localparam logic [LIM_W-1:0] LIM_4GB = LIM_W'(1) << (GB4_BIT - LIM_LSB);
endpackage

// File: rtl/udl_reg.sv
module udl_reg
  import udl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             tlock_i,
  input  logic [BYTES-1:0] be_i,
  input  logic [LIM_W-1:0] wlim_i,
  input  logic             wlock_i,
  output logic [LIM_W-1:0] lim_o,
  output logic             lock_o
);
  logic [LIM_W-1:0] lim_q, lim_d;
  logic             lock_q, lock_d;
  logic             wr_ok;
  logic [LIM_W-1:0] bit_en;

  assign wr_ok = wr_i && !lock_q && !tlock_i;

  for (genvar k = 0; k < LIM_W; k++) begin : g_en
    assign bit_en[k] = be_i[(LIM_LSB + k) / 8];
  end

  always_comb begin
    lim_d  = lim_q;
    lock_d = lock_q;
    if (wr_ok) begin
      for (int k = 0; k < LIM_W; k++)
        if (bit_en[k]) lim_d[k] = wlim_i[k];
      if (be_i[LOCK_POS / 8]) lock_d = wlock_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q  <= '0;
      lock_q <= 1'b0;
    end else if (wr_ok) begin
      lim_q  <= lim_d;
      lock_q <= lock_d;
    end
  end

  assign lim_o  = lim_q;
  assign lock_o = lock_q;

  a_r5_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  a_r5_lock_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(lim_q));
  a_r6_tlock_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlock_i |=> ($stable(lim_q) && $stable(lock_q)));
  a_r2_full_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !lock_q && !tlock_i && (&be_i)) |=> (lim_q == $past(wlim_i)));
endmodule

// File: rtl/udl_cmp.sv
module udl_cmp
  import udl_pkg::*;
#(
  parameter int HADDR_W = 39
) (
  input  logic [HADDR_W-1:0] addr_i,
  input  logic [LIM_W-1:0]   lim_i,
  output logic               hit_o
);
  logic above_4g, below_lim, in_range;

  assign above_4g  = |addr_i[LIM_MSB:GB4_BIT];
  assign below_lim = addr_i[LIM_MSB:LIM_LSB] < lim_i;

  if (HADDR_W > LIM_MSB + 1) begin : g_wide
    assign in_range = ~|addr_i[HADDR_W-1:LIM_MSB+1];
  end else begin : g_exact
    assign in_range = 1'b1;
  end

  assign hit_o = in_range && above_4g && below_lim;
endmodule

// File: rtl/upper_dram_limit.sv
module upper_dram_limit
  import udl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_sel_i,
  input  logic        cfg_we_i,
  input  logic [7:0]  cfg_be_i,
  input  logic [63:0] cfg_wdata_i,
  output logic [63:0] cfg_rdata_o,
  input  logic        tlock_i,
  input  logic [38:0] host_addr_i,
  output logic        dram_hit_o
);
  logic [LIM_W-1:0] lim;
  logic             lock;
  logic             unused_wbits;

  assign unused_wbits = ^{cfg_wdata_i[REG_W-1:LIM_MSB+1],
                          cfg_wdata_i[LIM_LSB-1:LOCK_POS+1]};

  udl_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_sel_i && cfg_we_i),
    .tlock_i (tlock_i),
    .be_i    (cfg_be_i),
    .wlim_i  (cfg_wdata_i[LIM_MSB:LIM_LSB]),
    .wlock_i (cfg_wdata_i[LOCK_POS]),
    .lim_o   (lim),
    .lock_o  (lock)
  );

  udl_cmp #(.HADDR_W(39)) u_cmp (
    .addr_i (host_addr_i),
    .lim_i  (lim),
    .hit_o  (dram_hit_o)
  );

  always_comb begin
    cfg_rdata_o                   = '0;
    cfg_rdata_o[LIM_MSB:LIM_LSB]  = lim;
    cfg_rdata_o[LOCK_POS]         = lock;
  end

  a_r3_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[63:39] == '0) && (cfg_rdata_o[19:1] == '0));
  a_r7_hit_above_4g: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_hit_o |-> (host_addr_i >= 39'h1_0000_0000));
  a_r7_hit_below_lim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_hit_o |-> (host_addr_i < {cfg_rdata_o[38:20], 20'h0}));
  a_r8_empty_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[38:20] <= LIM_4GB) |-> !dram_hit_o);
endmodule

// File: tb/sim_upper_dram_limit.sv
module sim_upper_dram_limit;
  localparam time CLK_PERIOD = 10;

  typedef struct {
    string       tag;
    bit          is_hit;
    logic [63:0] exp;
  } item_t;

  logic        clk, rst_n, sel, we, tlock, hit;
  logic [7:0]  be;
  logic [63:0] wdata, rdata;
  logic [38:0] haddr;

  item_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  upper_dram_limit u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_sel_i(sel), .cfg_we_i(we),
    .cfg_be_i(be), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .tlock_i(tlock), .host_addr_i(haddr), .dram_hit_o(hit)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops expected items and compares against outputs
  initial begin
    forever begin
      item_t it;
      logic [63:0] act;
      wait (sb.size() != 0);
      it  = sb.pop_front();
      act = it.is_hit ? {63'h0, hit} : rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] b, input logic [63:0] d);
    @(negedge clk);
    sel = 1; we = 1; be = b; wdata = d;
    @(negedge clk);
    sel = 0; we = 0; be = '0; wdata = '0;
  endtask

  task automatic exp_rd(input string tag, input logic [63:0] e);
    #1;
    sb.push_back('{tag, 1'b0, e});
    wait (sb.size() == 0);
  endtask

  task automatic exp_hit(input string tag, input logic [38:0] a, input bit e);
    haddr = a;
    #1;
    sb.push_back('{tag, 1'b1, {63'h0, e}});
    wait (sb.size() == 0);
  endtask

  initial begin
    sel = 0; we = 0; be = '0; wdata = '0; tlock = 0; haddr = '0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    exp_rd("R1 reset value", 64'h0);
    exp_hit("R1 no hit after reset", 39'h1_0000_0000, 0);
    // R2 full write
    wr(8'hFF, 64'h0000_0004_0000_0000);
    exp_rd("R2 limit stored", 64'h0000_0004_0000_0000);
    // R3 reserved bits
    wr(8'hFF, 64'hFFFF_FFFF_FFFF_FFFE);
    exp_rd("R3 reserved read zero", 64'h0000_007F_FFF0_0000);
    wr(8'hFF, 64'h0000_0004_0000_0000);
    // R4 byte enables
    wr(8'h10, 64'h0000_0008_0000_0000);
    exp_rd("R4 byte4 only", 64'h0000_0008_0000_0000);
    wr(8'h04, 64'hFFFF_FFFF_FFFF_FFFF);
    exp_rd("R4 byte2 only", 64'h0000_0008_00F0_0000);
    wr(8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
    exp_rd("R4 no enables", 64'h0000_0008_00F0_0000);
    // R7 / R9 window edges, limit = 0x8_00F0_0000
    exp_hit("R7 at 4GB", 39'h1_0000_0000, 1);
    exp_hit("R7 below 4GB", 39'h0_FFFF_FFFF, 0);
    exp_hit("R9 limit minus one", 39'h8_00EF_FFFF, 1);
    exp_hit("R7 at limit", 39'h8_00F0_0000, 0);
    exp_hit("R7 top address", 39'h7F_FFFF_FFFF, 0);
    // R8 degenerate windows
    wr(8'hFF, 64'h0000_0001_0000_0000);
    exp_hit("R8 limit 4GB", 39'h1_0000_0000, 0);
    wr(8'hFF, 64'h0000_0000_8000_0000);
    exp_hit("R8 limit 2GB hi", 39'h1_0000_0000, 0);
    exp_hit("R8 limit 2GB lo", 39'h0_4000_0000, 0);
    // R6 trusted lock
    tlock = 1;
    wr(8'hFF, 64'h0000_0002_0000_0001);
    exp_rd("R6 write blocked", 64'h0000_0000_8000_0000);
    tlock = 0;
    exp_rd("R6 still unchanged", 64'h0000_0000_8000_0000);
    // R5 self lock
    wr(8'hFF, 64'h0000_0003_0000_0001);
    exp_rd("R5 lock set", 64'h0000_0003_0000_0001);
    wr(8'hFF, 64'h0);
    exp_rd("R5 write ignored", 64'h0000_0003_0000_0001);
    exp_hit("R5 window kept", 39'h2_8000_0000, 1);
    done = 1;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
  end

  initial begin
    wait (done || $time > CLK_PERIOD * 5000);
    #(CLK_PERIOD);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule